// File: doc/BRIEF.md
# Watchdog Timer with Prescaler

This block is the watchdog counter of a small microcontroller. It counts ticks from one of two sources: a tick input that stands for a free-running on-chip RC oscillator, or an instruction clock made inside the block by dividing the system clock by four. A static configuration input picks the source. The ticks first pass through a fixed divide-by-256 stage, and then through a prescaler whose ratio is set by a 3-bit select. When the whole chain reaches its terminal count, the block raises a one-cycle time-out pulse, which the chip uses to start a reset.

Software keeps the watchdog quiet by pulsing the clear input before the period ends. A halt input shows that the core is halted. With the instruction clock as source, halt stops the count. With the RC source, counting goes on during halt. A static enable input can switch the watchdog off completely.

Top module: `wdog_timer`

## Requirements
- R1: After the asynchronous reset, `timeout_o` is low and every counter stage is zero. The first time-out after reset release comes after exactly 256 x 2^sel source ticks.
- R2: With the RC source (`use_rc_i` = 1), each cycle in which `rc_tick_i` is high is one tick. A time-out comes after 256 x 2^`sel_i` ticks, for every `sel_i` value from 0 (ratio 1:1) to 7 (ratio 1:128).
- R3: With the instruction clock (`use_rc_i` = 0), the source makes one tick every 4 system clock cycles. The period is therefore 4 x 256 x 2^`sel_i` clock cycles.
- R4: `timeout_o` is high for exactly one cycle at each terminal count. All counters then wrap to zero and counting goes on, so the time-outs repeat with the same period.
- R5: A high `clear_i` resets the fixed divider, the prescaler and the instruction-clock phase to zero. A full period then restarts from the next cycle.
- R6: When `clear_i` is high in the same cycle as the terminal count, the clear wins and no time-out is produced.
- R7: With the instruction clock as source, each cycle in which `halt_i` is high freezes the count. Each such cycle delays the time-out by one cycle.
- R8: With the RC source, `halt_i` has no effect on the time-out timing.
- R9: When `wdt_en_i` is low, no time-out is ever produced, and clear and halt have no effect. The count is held at zero, so after `wdt_en_i` is raised a full period runs from zero.
- R10: A change of `sel_i` while counting does not reset the count. The new ratio takes effect from the next period boundary, that is, when the whole count is back at zero.
- R11: With the RC source, cycles in which `rc_tick_i` is low do not advance the count. Sparse ticks therefore stretch the period in proportion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdt_en_i | input | 1 | Static enable; 0 turns the watchdog off |
| use_rc_i | input | 1 | Static source select: 1 = RC tick, 0 = instruction clock |
| rc_tick_i | input | 1 | One-cycle tick from the RC oscillator |
| halt_i | input | 1 | Core is halted |
| clear_i | input | 1 | Software clear of the watchdog |
| sel_i | input | 3 | Prescaler select; ratio is 2^sel_i |
| timeout_o | output | 1 | One-cycle time-out pulse |

## Verification
Every internal state of this block shows at the ports only through when `timeout_o` fires. A divider or prescaler count that is off by one moves the pulse by a whole number of source ticks. A wrong ratio latch moves it by a whole number of base periods. A clear or halt that leaks through shifts the pulse, or adds or removes a pulse. In each case the error shows up no later than the first time-out of the affected period. The scoreboard therefore predicts the exact cycle of every pulse and treats any pulse that it did not predict as an error.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned BASE_W = 8;   // fixed divide-by-256
  localparam int unsigned SEL_W  = 3;   // prescaler select, ratio 2^sel
  localparam int unsigned IDIV_W = 2;   // instruction clock = sysclk / 4

  typedef enum logic {
    SRC_ICLK = 1'b0,
    SRC_RC   = 1'b1
  } wdog_src_e;
endpackage

// File: rtl/wdog_tick_src.sv
module wdog_tick_src #(
  parameter int unsigned IDIV_W = wdog_pkg::IDIV_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic use_rc_i,
  input  logic rc_tick_i,
  input  logic halt_i,
  input  logic clear_i,
  output logic tick_o
);
  import wdog_pkg::*;

  wdog_src_e src;
  logic      iclk_tick;

  assign src = wdog_src_e'(use_rc_i);

  generate
    if (IDIV_W == 0) begin : g_no_div
      assign iclk_tick = !halt_i;
    end else begin : g_div
      logic [IDIV_W-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                div_q <= '0;
        else if (!en_i || clear_i)  div_q <= '0;
        else if (!halt_i)           div_q <= div_q + 1'b1;
      end
      // halt freezes the instruction clock
      assign iclk_tick = !halt_i && (div_q == {IDIV_W{1'b1}});

      // R7: frozen divider during halt
      assert_div_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (halt_i && en_i && !clear_i) |=> $stable(div_q));
    end
  endgenerate

  always_comb begin
    tick_o = 1'b0;
    if (en_i && !clear_i) begin
      case (src)
        SRC_RC:   tick_o = rc_tick_i;
        default:  tick_o = iclk_tick;
      endcase
    end
  end
endmodule

// File: rtl/wdog_base_div.sv
module wdog_base_div #(
  parameter int unsigned BASE_W = wdog_pkg::BASE_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clear_i,
  input  logic tick_i,
  output logic carry_o,
  output logic zero_o
);
  logic [BASE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || clear_i) cnt_q <= '0;
    else if (tick_i)           cnt_q <= cnt_q + 1'b1;
  end

  assign carry_o = tick_i && (cnt_q == {BASE_W{1'b1}});
  assign zero_o  = (cnt_q == '0);

  // R4: stage wraps to zero on carry
  assert_base_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |=> zero_o);
  // R5: clear empties the stage
  assert_base_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> zero_o);
  // R11: no tick, no movement
  assert_base_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clear_i && en_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned SEL_W = wdog_pkg::SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             base_zero_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             term_o
);
  localparam int unsigned PRE_W = (1 << SEL_W) - 1;

  logic [SEL_W-1:0] ratio_q;
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W:0]   one_hot;
  logic [PRE_W:0]   limit_full;
  logic [PRE_W-1:0] limit;
  logic             at_boundary;

  assign at_boundary = base_zero_i && (cnt_q == '0);

  // ratio only follows the select while the whole chain sits at zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ratio_q <= '0;
    else if (at_boundary) ratio_q <= sel_i;
  end

  assign one_hot    = {{PRE_W{1'b0}}, 1'b1} << ratio_q;
  assign limit_full = one_hot - {{PRE_W{1'b0}}, 1'b1};
  assign limit      = limit_full[PRE_W-1:0];
  assign term_o     = step_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || clear_i) cnt_q <= '0;
    else if (term_o)           cnt_q <= '0;
    else if (step_i)           cnt_q <= cnt_q + 1'b1;
  end

  // R10: ratio held while a period is in progress
  assert_ratio_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !at_boundary |=> $stable(ratio_q));
  // R4: prescaler returns to zero after terminal count
  assert_pre_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_o && !clear_i) |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int unsigned BASE_W = wdog_pkg::BASE_W,
  parameter int unsigned SEL_W  = wdog_pkg::SEL_W,
  parameter int unsigned IDIV_W = wdog_pkg::IDIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wdt_en_i,
  input  logic             use_rc_i,
  input  logic             rc_tick_i,
  input  logic             halt_i,
  input  logic             clear_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             timeout_o
);
  logic src_tick;
  logic base_carry;
  logic base_zero;
  logic pre_term;
  logic timeout_q;

  wdog_tick_src #(.IDIV_W(IDIV_W)) u_src (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (wdt_en_i),
    .use_rc_i  (use_rc_i),
    .rc_tick_i (rc_tick_i),
    .halt_i    (halt_i),
    .clear_i   (clear_i),
    .tick_o    (src_tick)
  );

  wdog_base_div #(.BASE_W(BASE_W)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (wdt_en_i),
    .clear_i (clear_i),
    .tick_i  (src_tick),
    .carry_o (base_carry),
    .zero_o  (base_zero)
  );

  wdog_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (wdt_en_i),
    .clear_i     (clear_i),
    .step_i      (base_carry),
    .base_zero_i (base_zero),
    .sel_i       (sel_i),
    .term_o      (pre_term)
  );

  // clear has priority over a coincident terminal count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) timeout_q <= 1'b0;
    else         timeout_q <= wdt_en_i && pre_term && !clear_i;
  end

  assign timeout_o = timeout_q;

  assert_pulse_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
  assert_clear_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !timeout_o);
  assert_off_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdt_en_i |=> !timeout_o);
  // R7: halted with instruction clock, nothing advances
  assert_halt_no_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !use_rc_i) |-> !src_tick);
  // R8: RC ticks pass regardless of halt
  assert_rc_in_halt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (use_rc_i && wdt_en_i && !clear_i && rc_tick_i) |-> src_tick);
endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
  localparam int CLK_P    = 10;
  localparam int BASE     = 256;
  localparam int IDIV     = 4;
  localparam int WD_LIMIT = 190000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic       use_rc;
  logic       rc_tick;
  logic       halt;
  logic       clr;
  logic [2:0] sel;
  logic       timeout;

  always #(CLK_P/2) clk = ~clk;

  wdog_timer u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wdt_en_i  (en),
    .use_rc_i  (use_rc),
    .rc_tick_i (rc_tick),
    .halt_i    (halt),
    .clear_i   (clr),
    .sel_i     (sel),
    .timeout_o (timeout)
  );

  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  int    pulses = 0;
  int    exp_q[$];
  string cur_req = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: samples a quarter period after the edge
  always begin
    @(posedge clk);
    #(CLK_P/4);
    if (exp_q.size() > 0 && exp_q[0] == cyc) begin
      total++;
      if (!timeout) begin
        bad++;
        $display("FAIL %s: missing time-out at cycle %0d actual=0 expected=1", cur_req, cyc);
      end
      void'(exp_q.pop_front());
    end else if (timeout) begin
      total++;
      bad++;
      $display("FAIL %s: unexpected time-out at cycle %0d actual=1 expected=0", cur_req, cyc);
    end
    if (timeout) pulses++;
  end

  always @(posedge clk) begin
    if (cyc >= WD_LIMIT) begin
      total++;
      bad++;
      $display("FAIL %s: watchdog expired actual=%0d expected<%0d", cur_req, cyc, WD_LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // clear with the given source and select, returns the clear-request cycle
  task automatic start(input bit rc, input int s, output int a);
    a       = cyc;
    use_rc  = rc;
    sel     = 3'(s);
    clr     = 1'b1;
    rc_tick = rc;
    @(negedge clk);
    clr     = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic idle();
    use_rc  = 1'b1;
    rc_tick = 1'b0;
    halt    = 1'b0;
  endtask

  initial begin
    int a;
    int p0;
    rst_n = 1'b0; en = 1'b1; use_rc = 1'b1; rc_tick = 1'b0;
    halt = 1'b0; clr = 1'b0; sel = 3'd0;
    step(3);
    // R1: reset state
    chk(timeout == 1'b0, "R1", int'(timeout), 0);
    a = cyc;
    rst_n = 1'b1;
    rc_tick = 1'b1;
    exp_q.push_back(a + BASE);        // R1: first period from zero
    drain(); idle();

    // R2: every select value on the RC source
    cur_req = "R2";
    for (int s = 0; s < 8; s++) begin
      start(1'b1, s, a);
      exp_q.push_back(a + 1 + (BASE << s));
      drain();
    end
    idle();

    // R4: periodic single pulses
    cur_req = "R4";
    start(1'b1, 1, a);
    for (int k = 1; k <= 3; k++) exp_q.push_back(a + 1 + k * (BASE << 1));
    drain(); idle();
    step(2);
    chk(timeout == 1'b0, "R4", int'(timeout), 0);

    // R3: instruction clock source
    cur_req = "R3";
    start(1'b0, 0, a);
    exp_q.push_back(a + 1 + IDIV * BASE);
    drain(); idle();
    start(1'b0, 2, a);
    exp_q.push_back(a + 1 + IDIV * (BASE << 2));
    drain(); idle();

    // R7: halt freezes instruction-clock counting
    cur_req = "R7";
    start(1'b0, 0, a);
    exp_q.push_back(a + 1 + IDIV * BASE + 50);
    step(99);
    halt = 1'b1;
    step(50);
    halt = 1'b0;
    drain(); idle();

    // R8: halt ignored on RC source
    cur_req = "R8";
    start(1'b1, 0, a);
    exp_q.push_back(a + 1 + BASE);
    step(49);
    halt = 1'b1;
    step(100);
    halt = 1'b0;
    drain(); idle();

    // R5: mid-period clear restarts
    cur_req = "R5";
    start(1'b1, 0, a);
    step(99);
    clr = 1'b1;
    step(1);
    clr = 1'b0;
    exp_q.push_back(a + 101 + BASE);
    drain(); idle();

    // R6: clear at terminal count
    cur_req = "R6";
    start(1'b1, 0, a);
    p0 = pulses;
    step(a + BASE - cyc);
    clr = 1'b1;
    step(1);
    clr = 1'b0;
    chk(pulses == p0, "R6", pulses - p0, 0);
    exp_q.push_back(a + 1 + BASE + BASE);
    drain(); idle();

    // R10: select change mid-period
    cur_req = "R10";
    start(1'b1, 0, a);
    exp_q.push_back(a + 1 + BASE);
    exp_q.push_back(a + 1 + BASE + (BASE << 1));
    step(9);
    sel = 3'd1;
    drain(); idle();

    // R11: sparse RC ticks
    cur_req = "R11";
    a = cyc;
    use_rc = 1'b1; sel = 3'd0; clr = 1'b1; rc_tick = 1'b0;
    @(negedge clk);
    clr = 1'b0;
    exp_q.push_back(a + 3 * BASE - 1);
    for (int k = 0; k < BASE; k++) begin
      rc_tick = 1'b1;
      @(negedge clk);
      rc_tick = 1'b0;
      step(2);
    end
    drain(); idle();

    // R9: disabled, then enabled from zero
    cur_req = "R9";
    en = 1'b0;
    rc_tick = 1'b1;
    p0 = pulses;
    for (int k = 0; k < 6; k++) begin
      step(400);
      clr = 1'b1; halt = 1'b1;
      step(1);
      clr = 1'b0; halt = 1'b0;
    end
    chk(pulses == p0, "R9", pulses - p0, 0);
    a = cyc;
    en = 1'b1;
    exp_q.push_back(a + BASE);
    drain(); idle();

    step(4);
    chk(exp_q.size() == 0, "R4", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule